// File: doc/BRIEF.md
# Configurable Serial Transmitter with Line Break

This block turns bytes into asynchronous serial frames. Characters are written into a small queue. When the transmitter is idle and allowed to send, it takes the oldest character and sends it on a single line that idles high. A frame is a low start bit, then 5 to 8 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. Every bit lasts sixteen pulses of an oversampling tick, which comes from a baud generator outside the block.

The queue has two sizes. In buffered mode it holds several characters. In holding mode it holds a single character. A forced break request drives the line low. A clear-to-send input can hold back the start of new characters. The block reports queue full, queue empty and a busy flag. Busy covers both characters that are waiting and the character being sent.

The frame format is captured when a character is taken from the queue. Changing the format therefore has no effect on a frame that is already being sent.

Top module: `uart_tx_core`

## Requirements
- R1: After reset the serial line is high, the queue is empty (`fifoEmpty`=1, `fifoFull`=0) and `busy` is 0.
- R2: `wordLenSel` sets the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. A frame starts with one low start bit and then sends the data least significant bit first. Each bit lasts exactly 16 cycles in which `tick` is high.
- R3: With `parityEn`=1, one parity bit follows the data. With `stickSel`=0 the parity bit makes the count of ones in the data and parity bits even when `evenSel`=1, and odd when `evenSel`=0. With `stickSel`=1 the parity bit is the inverse of `evenSel`. With `parityEn`=0 no parity bit is sent.
- R4: The frame ends with one high stop bit, or two when `twoStop`=1.
- R5: The queue holds 4 characters (parameter DEPTH) when `fifoEn`=1 and 1 character when `fifoEn`=0. `fifoFull` and `fifoEmpty` report the queue only. While a character is being shifted out and nothing is waiting, `fifoEmpty` is 1.
- R6: A write while `fifoFull`=1 is dropped and leaves the queued characters unchanged.
- R7: `busy` is 1 from the cycle after a write, even when `txEnable`=0. It stays 1 until the last stop bit of the last queued character has ended, and then falls.
- R8: While `txEnable`=0 no new character starts. Clearing `txEnable` during a frame still lets that frame finish in full.
- R9: With `ctsFlowEn`=1 a character starts only while `ctsActive`=1. With `ctsFlowEn`=0, `ctsActive` is ignored.
- R10: While `breakReq`=1 the line is held low. The low level begins only after the current frame, including its stop bits, has finished. The line returns high one cycle after `breakReq` is cleared.
- R11: Characters leave the block in the order in which they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrData | input | 8 | Character to queue |
| wrEn | input | 1 | Write strobe for `wrData` |
| fifoEn | input | 1 | 1 = buffered queue, 0 = single holding entry |
| wordLenSel | input | 2 | Data bit count code (5 to 8 bits) |
| parityEn | input | 1 | Adds a parity bit |
| evenSel | input | 1 | Even parity when 1, odd parity when 0 |
| stickSel | input | 1 | Fixed parity bit equal to the inverse of `evenSel` |
| twoStop | input | 1 | Sends two stop bits |
| breakReq | input | 1 | Forces the line low after the current frame |
| txEnable | input | 1 | Allows new characters to start |
| ctsFlowEn | input | 1 | Enables clear-to-send gating |
| ctsActive | input | 1 | Clear-to-send asserted (active high) |
| tick | input | 1 | 16x bit-rate pulse |
| txLine | output | 1 | Serial output |
| fifoFull | output | 1 | Queue full |
| fifoEmpty | output | 1 | Queue empty |
| busy | output | 1 | A character is waiting or being sent |

## Verification
Two functions can coincide in the same cycle: a break request can arrive while a frame is being sent. The bench raises `breakReq` partway through the data bits. It then decodes the whole frame, checks that the stop bits are still high, and checks that the line goes low right after the stop bits end. Clearing `txEnable` in the middle of a frame is tested the same way: the full frame must still appear, and no later character may start. The main sweep covers every word length, every parity mode and both stop counts. Expected data and parity bits are computed arithmetically in the bench.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int CHAR_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP,
    ST_BREAK
  } txState_t;

  // strobes issued by the control unit to the datapath
  typedef struct packed {
    logic loadChar;   // pop the queue head into the shifter
    logic shiftBit;   // advance to the next data bit
  } txStrobes_t;

  // datapath view returned to the control unit
  typedef struct packed {
    logic queueEmpty;
    logic lastDataBit;
    logic withParity;
    logic twoStop;
    logic dataBit;
    logic parityBit;
  } txFrameInfo_t;
endpackage

// File: rtl/uart_tx_datapath.sv
module uart_tx_datapath import uart_tx_pkg::*; #(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CHAR_W-1:0] wrData,
  input  logic              wrEn,
  input  logic              fifoEn,
  input  logic [1:0]        wordLenSel,
  input  logic              parityEn,
  input  logic              evenSel,
  input  logic              stickSel,
  input  logic              twoStop,
  input  txStrobes_t        strobes,
  output txFrameInfo_t      info,
  output logic              fifoFull,
  output logic              fifoEmpty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CHAR_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [CNT_W-1:0]  count;
  logic [CNT_W-1:0]  capacity;
  logic              doWrite, doPop;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign capacity  = fifoEn ? CNT_W'(DEPTH) : CNT_W'(1);
  assign fifoFull  = (count >= capacity);
  assign fifoEmpty = (count == '0);
  assign doWrite   = wrEn && !fifoFull;
  assign doPop     = strobes.loadChar && !fifoEmpty;

  always_ff @(posedge clk) begin
    if (doWrite) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doWrite) wrPtr <= bump(wrPtr);
      if (doPop)   rdPtr <= bump(rdPtr);
      case ({doWrite, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // frame capture at load time
  logic [CHAR_W-1:0] charMask, headChar;
  logic [3:0]        bitCount;
  logic              parityCalc;

  assign charMask   = {CHAR_W{1'b1}} >> (2'd3 - wordLenSel);
  assign headChar   = mem[rdPtr] & charMask;
  assign bitCount   = 4'd5 + {2'b00, wordLenSel};
  assign parityCalc = stickSel ? ~evenSel : (evenSel ? ^headChar : ~^headChar);

  logic [CHAR_W-1:0] shiftQ;
  logic [3:0]        bitsLeft;
  logic              parBitQ, parEnQ, twoStopQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ   <= '0;
      bitsLeft <= '0;
      parBitQ  <= 1'b0;
      parEnQ   <= 1'b0;
      twoStopQ <= 1'b0;
    end else if (doPop) begin
      shiftQ   <= headChar;
      bitsLeft <= bitCount;
      parBitQ  <= parityCalc;
      parEnQ   <= parityEn;
      twoStopQ <= twoStop;
    end else if (strobes.shiftBit) begin
      shiftQ   <= shiftQ >> 1;
      bitsLeft <= bitsLeft - 1'b1;
    end
  end

  assign info.queueEmpty  = fifoEmpty;
  assign info.lastDataBit = (bitsLeft == 4'd1);
  assign info.withParity  = parEnQ;
  assign info.twoStop     = twoStopQ;
  assign info.dataBit     = shiftQ[0];
  assign info.parityBit   = parBitQ;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH)); // R5
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadChar |-> !fifoEmpty); // R5
  AST_FULL_WRITE_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && fifoFull && !strobes.loadChar) |=> $stable(count)); // R6
endmodule

// File: rtl/uart_tx_ctrl.sv
module uart_tx_ctrl import uart_tx_pkg::*; #(
  parameter int TICKS_PER_BIT = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         tick,
  input  logic         txEnable,
  input  logic         ctsFlowEn,
  input  logic         ctsActive,
  input  logic         breakReq,
  input  txFrameInfo_t info,
  output txStrobes_t   strobes,
  output logic         txLine,
  output logic         frameActive
);
  localparam int TCNT_W = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;

  txState_t          curState, nextState;
  logic [TCNT_W-1:0] tickCnt;
  logic              secondStop;
  logic              inFrame, bitEnd, clearToSend, canStart;

  assign inFrame     = curState inside {ST_START, ST_DATA, ST_PARITY, ST_STOP};
  assign bitEnd      = inFrame && tick && (tickCnt == TCNT_W'(TICKS_PER_BIT - 1));
  assign clearToSend = !ctsFlowEn || ctsActive;
  assign canStart    = txEnable && clearToSend && !info.queueEmpty;

  always_comb begin
    nextState = curState;
    strobes   = '0;
    case (curState)
      ST_IDLE: begin
        if (breakReq) begin
          nextState = ST_BREAK;
        end else if (canStart) begin
          nextState        = ST_START;
          strobes.loadChar = 1'b1;
        end
      end
      ST_START:  if (bitEnd) nextState = ST_DATA;
      ST_DATA: begin
        if (bitEnd) begin
          strobes.shiftBit = 1'b1;
          if (info.lastDataBit) nextState = info.withParity ? ST_PARITY : ST_STOP;
        end
      end
      ST_PARITY: if (bitEnd) nextState = ST_STOP;
      ST_STOP:   if (bitEnd && (!info.twoStop || secondStop)) nextState = ST_IDLE;
      ST_BREAK:  if (!breakReq) nextState = ST_IDLE;
      default:   nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curState   <= ST_IDLE;
      tickCnt    <= '0;
      secondStop <= 1'b0;
    end else begin
      curState <= nextState;
      if (strobes.loadChar || bitEnd) tickCnt <= '0;
      else if (inFrame && tick)       tickCnt <= tickCnt + 1'b1;
      if (strobes.loadChar)                     secondStop <= 1'b0;
      else if (curState == ST_STOP && bitEnd)   secondStop <= 1'b1;
    end
  end

  always_comb begin
    case (curState)
      ST_START:  txLine = 1'b0;
      ST_DATA:   txLine = info.dataBit;
      ST_PARITY: txLine = info.parityBit;
      ST_BREAK:  txLine = 1'b0;
      default:   txLine = 1'b1;
    endcase
  end

  assign frameActive = inFrame;

  AST_TICK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (inFrame && !tick) |=> $stable(curState)); // R2
  AST_START_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_IDLE && !txEnable) |=> curState != ST_START); // R8
  AST_START_CTS: assert property (@(posedge clk) disable iff (!rstN)
    (curState == ST_IDLE && ctsFlowEn && !ctsActive) |=> curState != ST_START); // R9
  AST_BREAK_AFTER_CHAR: assert property (@(posedge clk) disable iff (!rstN)
    (curState inside {ST_START, ST_DATA, ST_PARITY}) |=> curState != ST_BREAK); // R10
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core import uart_tx_pkg::*; #(
  parameter int DEPTH         = 4,
  parameter int TICKS_PER_BIT = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] wrData,
  input  logic       wrEn,
  input  logic       fifoEn,
  input  logic [1:0] wordLenSel,
  input  logic       parityEn,
  input  logic       evenSel,
  input  logic       stickSel,
  input  logic       twoStop,
  input  logic       breakReq,
  input  logic       txEnable,
  input  logic       ctsFlowEn,
  input  logic       ctsActive,
  input  logic       tick,
  output logic       txLine,
  output logic       fifoFull,
  output logic       fifoEmpty,
  output logic       busy
);
  txStrobes_t   strobes;
  txFrameInfo_t info;
  logic         frameActive;

  uart_tx_datapath #(.DEPTH(DEPTH)) i_datapath (
    .clk(clk), .rstN(rstN), .wrData(wrData), .wrEn(wrEn), .fifoEn(fifoEn),
    .wordLenSel(wordLenSel), .parityEn(parityEn), .evenSel(evenSel),
    .stickSel(stickSel), .twoStop(twoStop), .strobes(strobes), .info(info),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty)
  );

  uart_tx_ctrl #(.TICKS_PER_BIT(TICKS_PER_BIT)) i_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .txEnable(txEnable),
    .ctsFlowEn(ctsFlowEn), .ctsActive(ctsActive), .breakReq(breakReq),
    .info(info), .strobes(strobes), .txLine(txLine), .frameActive(frameActive)
  );

  assign busy = !fifoEmpty || frameActive;
endmodule

// File: tb/test_uart_tx_core.sv
module test_uart_tx_core;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] wrData = '0;
  logic       wrEn = 1'b0, fifoEn = 1'b0;
  logic [1:0] wordLenSel = 2'b11;
  logic       parityEn = 1'b0, evenSel = 1'b0, stickSel = 1'b0, twoStop = 1'b0;
  logic       breakReq = 1'b0, txEnable = 1'b0, ctsFlowEn = 1'b0, ctsActive = 1'b0;
  logic       tick = 1'b0;
  logic       txLine, fifoFull, fifoEmpty, busy;
  int         checks = 0, failures = 0;
  int         tickDiv = 1;

  always #5 clk = ~clk;

  uart_tx_core i_uart_tx_core (
    .clk(clk), .rstN(rstN), .wrData(wrData), .wrEn(wrEn), .fifoEn(fifoEn),
    .wordLenSel(wordLenSel), .parityEn(parityEn), .evenSel(evenSel),
    .stickSel(stickSel), .twoStop(twoStop), .breakReq(breakReq),
    .txEnable(txEnable), .ctsFlowEn(ctsFlowEn), .ctsActive(ctsActive),
    .tick(tick), .txLine(txLine), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
    .busy(busy)
  );

  initial begin
    int phase = 0;
    forever begin
      @(negedge clk);
      phase = (phase + 1) % tickDiv;
      tick  = (phase == 0);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic putChar(input logic [7:0] v);
    @(negedge clk);
    wrData = v; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic setFormat(input int wl, input int pm, input int st);
    wordLenSel = 2'(wl);
    parityEn   = (pm != 0);
    evenSel    = (pm == 2) || (pm == 4);
    stickSel   = (pm >= 3);
    twoStop    = (st != 0);
  endtask

  task automatic waitFall(input int limit, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (!txLine) begin seen = 1'b1; break; end
    end
  endtask

  // decodes one frame at 1 tick per clock; returns just after the last stop bit
  task automatic rxFrame(input int nb, input bit hasPar, input int nStop,
                         output logic [7:0] d, output logic p, output bit ok,
                         output bit busyAtStop);
    bit seen;
    d = '0; p = 1'b0; busyAtStop = 1'b0;
    waitFall(4000, seen);
    ok = seen;
    if (!seen) return;
    repeat (8) @(negedge clk);
    if (txLine) ok = 1'b0;
    for (int i = 0; i < nb; i++) begin
      repeat (16) @(negedge clk);
      d[i] = txLine;
    end
    if (hasPar) begin
      repeat (16) @(negedge clk);
      p = txLine;
    end
    for (int s = 0; s < nStop; s++) begin
      repeat (16) @(negedge clk);
      if (!txLine) ok = 1'b0;
      busyAtStop = busy;
    end
    repeat (8) @(negedge clk);
  endtask

  task automatic lineStaysHigh(input int n, output bit ok);
    ok = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!txLine) ok = 1'b0;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d, expD, q[4];
    logic       p, expP;
    bit         ok, bs, hi;
    int         width;

    repeat (3) @(negedge clk);
    chk(txLine == 1'b1, "R1 line after reset", int'(txLine), 1);
    chk(fifoEmpty == 1'b1 && fifoFull == 1'b0, "R1 flags after reset",
        int'({fifoFull, fifoEmpty}), 1);
    chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R7 sweep of every format
    txEnable = 1'b1;
    for (int wl = 0; wl < 4; wl++)
      for (int pm = 0; pm < 5; pm++)
        for (int st = 0; st < 2; st++)
          for (int ds = 0; ds < 2; ds++) begin
            logic [7:0] v;
            int nb;
            v  = ds ? 8'(8'hA7 ^ (wl * 37 + pm * 11 + st)) : 8'(8'h3C + wl * 29 + pm * 5 + st);
            nb = 5 + wl;
            expD = v & 8'(8'hFF >> (3 - wl));
            case (pm)
              1: expP = ~^expD;
              2: expP = ^expD;
              3: expP = 1'b1;
              default: expP = 1'b0;
            endcase
            setFormat(wl, pm, st);
            putChar(v);
            rxFrame(nb, pm != 0, st + 1, d, p, ok, bs);
            chk(ok, "R4 start/stop framing", int'(ok), 1);
            chk(d == expD, "R2 data bits", int'(d), int'(expD));
            if (pm != 0) chk(p == expP, "R3 parity bit", int'(p), int'(expP));
            chk(bs == 1'b1, "R7 busy during last stop bit", int'(bs), 1);
            chk(busy == 1'b0 && txLine == 1'b1, "R7 busy falls after last stop",
                int'({busy, txLine}), 1);
          end

    // R2 bit length counts ticks, not clocks
    setFormat(3, 0, 0);
    tickDiv = 3;
    putChar(8'h55);
    waitFall(4000, ok);
    while (!txLine) @(negedge clk);
    width = 0;
    while (txLine && width < 200) begin @(negedge clk); width++; end
    chk(width == 48, "R2 bit width at one tick per three clocks", width, 48);
    repeat (700) @(negedge clk);
    tickDiv = 1;
    repeat (4) @(negedge clk);

    // R5 R6 R7 R11 buffered queue while disabled
    txEnable = 1'b0;
    fifoEn   = 1'b1;
    q[0] = 8'h11; q[1] = 8'h82; q[2] = 8'hC3; q[3] = 8'h4E;
    putChar(q[0]);
    chk(busy == 1'b1, "R7 busy right after write while disabled", int'(busy), 1);
    for (int i = 1; i < 4; i++) putChar(q[i]);
    chk(fifoFull == 1'b1 && fifoEmpty == 1'b0, "R5 full at depth 4",
        int'({fifoFull, fifoEmpty}), 2);
    putChar(8'hEE);
    chk(fifoFull == 1'b1, "R6 still full after dropped write", int'(fifoFull), 1);
    lineStaysHigh(100, hi);
    chk(hi, "R8 nothing sent while disabled", int'(hi), 1);
    txEnable = 1'b1;
    for (int i = 0; i < 4; i++) begin
      rxFrame(8, 1'b0, 1, d, p, ok, bs);
      chk(ok && d == q[i], "R11 queue order", int'(d), int'(q[i]));
    end
    lineStaysHigh(300, hi);
    chk(hi && fifoEmpty, "R6 dropped character never sent", int'(hi), 1);

    // R5 R6 holding mode
    txEnable = 1'b0;
    fifoEn   = 1'b0;
    putChar(8'h9A);
    chk(fifoFull == 1'b1, "R5 holding entry full after one write", int'(fifoFull), 1);
    putChar(8'h65);
    txEnable = 1'b1;
    fork
      rxFrame(8, 1'b0, 1, d, p, ok, bs);
      begin
        repeat (30) @(negedge clk);
        chk(fifoEmpty == 1'b1 && busy == 1'b1, "R5 empty while shifting",
            int'({fifoEmpty, busy}), 3);
      end
    join
    chk(ok && d == 8'h9A, "R6 holding entry keeps first character", int'(d), 8'h9A);
    lineStaysHigh(300, hi);
    chk(hi, "R6 second holding write dropped", int'(hi), 1);

    // R8 disable mid-character
    fifoEn = 1'b1;
    putChar(8'hB4);
    fork
      rxFrame(8, 1'b0, 1, d, p, ok, bs);
      begin repeat (60) @(negedge clk); txEnable = 1'b0; end
    join
    chk(ok && d == 8'hB4, "R8 frame completes after disable", int'(d), 8'hB4);
    putChar(8'h27);
    lineStaysHigh(300, hi);
    chk(hi && busy, "R8 no start while disabled, busy held", int'({hi, busy}), 3);
    txEnable = 1'b1;
    rxFrame(8, 1'b0, 1, d, p, ok, bs);
    chk(ok && d == 8'h27, "R8 resumes on enable", int'(d), 8'h27);

    // R9 clear-to-send gating
    ctsFlowEn = 1'b1;
    ctsActive = 1'b0;
    putChar(8'h5D);
    lineStaysHigh(300, hi);
    chk(hi, "R9 held without clear-to-send", int'(hi), 1);
    ctsActive = 1'b1;
    rxFrame(8, 1'b0, 1, d, p, ok, bs);
    chk(ok && d == 8'h5D, "R9 sent on clear-to-send", int'(d), 8'h5D);
    ctsFlowEn = 1'b0;
    ctsActive = 1'b0;
    putChar(8'hA1);
    rxFrame(8, 1'b0, 1, d, p, ok, bs);
    chk(ok && d == 8'hA1, "R9 input ignored when gating off", int'(d), 8'hA1);

    // R10 break from idle
    @(negedge clk);
    breakReq = 1'b1;
    @(negedge clk);
    chk(txLine == 1'b0, "R10 break from idle", int'(txLine), 0);
    repeat (200) @(negedge clk);
    chk(txLine == 1'b0, "R10 break held", int'(txLine), 0);
    breakReq = 1'b0;
    @(negedge clk);
    chk(txLine == 1'b1, "R10 line high after break cleared", int'(txLine), 1);

    // R10 break requested mid-character
    setFormat(3, 2, 1);
    putChar(8'h3B);
    fork
      rxFrame(8, 1'b1, 2, d, p, ok, bs);
      begin repeat (50) @(negedge clk); breakReq = 1'b1; end
    join
    chk(ok && d == 8'h3B, "R10 frame intact before break", int'(d), 8'h3B);
    chk(p == ^8'h3B, "R10 parity intact before break", int'(p), int'(^8'h3B));
    @(negedge clk);
    chk(txLine == 1'b0, "R10 break starts after stop bits", int'(txLine), 0);
    breakReq = 1'b0;
    repeat (2) @(negedge clk);
    chk(txLine == 1'b1 && busy == 1'b0, "R10 idle after break",
        int'({txLine, busy}), 2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule